// File: doc/BRIEF.md
# Microcode Sequencer with Residence Table

This block is the control unit of a reconfigurable coprocessor. It accepts one dispatched command at a time. A command is one of three kinds: a partial reconfiguration set, a complete reconfiguration set, or an execute. Each command carries the memory address of a microcode routine. A small fully associative residence table records which routine addresses already have a copy in the on-chip control store.

On a hit, the sequencer issues the cached microinstructions to the custom unit, one per cycle. On a miss, it first picks a slot and sends a single-cycle burst read request to memory. It writes the fixed-length burst into that slot and then issues the routine. Every command ends with a one-cycle done pulse, and the block then returns to idle.

The control store is split into equal slots, one per table entry. A slot holds `BURST` words and starts at the entry index times `BURST`. Each table entry keeps a valid bit, an address tag, a partial flag and a saturating use counter. The use counter drives replacement.

Top module: `ucs_sequencer`

## Requirements
- R1: After reset the block is idle: `cmd_ready_o` is high and `busy_o`, `done_o`, `uop_valid_o` and `mem_req_o` are low. All table entries are invalid.
- R2: A command whose address hits a live entry makes no memory request. Its first microinstruction appears on `uop_o` with `uop_valid_o` high in the cycle after acceptance.
- R3: On a miss, `mem_req_o` is high for exactly one cycle, in the cycle after acceptance, with `mem_addr_o` equal to the command address. The block then takes exactly `BURST` words, one on each cycle with `mem_rvalid_i` high, starting the cycle after the request. It starts issuing in the cycle after the last word.
- R4: Microinstructions are issued one per cycle, in the order the words were stored. Bit `WORD_W-1` of each word is its end bit.
- R5: Issuing stops after the word whose end bit is set. `done_o` is high for one cycle, in the cycle after that word. In the next cycle the block is idle with `cmd_ready_o` high.
- R6: If no word of a routine carries the end bit, issuing stops after the `BURST`-th word. Done then follows as in R5.
- R7: While `busy_o` is high, `cmd_ready_o` is low, so a presented command is held off until the block is idle.
- R8: The kind code on `cmd_kind_i` is 0 for execute, 1 for partial set, 2 for complete set, and 3 behaves as execute. An entry loaded by a partial set is tagged partial. An entry loaded by any other kind is not.
- R9: Replacement on a miss follows a fixed order. The first choice is the lowest-index invalid entry. If none is invalid, the entry with the lowest use counter is replaced, and a tie goes to the lowest index. A load sets the counter to 1, and each hit adds 1, saturating at the counter maximum.
- R10: Accepting a complete set invalidates every entry tagged partial. A partial entry holding the complete set's own address counts as a miss for that command.
- R11: Entries not tagged partial survive a complete set and still hit afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command presented |
| cmd_ready_o | output | 1 | Command can be accepted (block idle) |
| cmd_kind_i | input | 2 | Command kind: 0 execute, 1 partial set, 2 complete set, 3 execute |
| cmd_addr_i | input | ADDR_W | Memory address of the microcode routine |
| mem_req_o | output | 1 | One-cycle burst read request |
| mem_addr_o | output | ADDR_W | Burst start address |
| mem_rvalid_i | input | 1 | Returned burst word valid |
| mem_rdata_i | input | WORD_W | Returned burst word |
| uop_valid_o | output | 1 | Microinstruction valid |
| uop_o | output | WORD_W | Microinstruction word; the top bit is the end bit |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Results are due at fixed points after acceptance, and each check samples at that cycle:
- A hit shows its first word one cycle after acceptance.
- A miss shows `mem_req_o` one cycle after acceptance.
- Burst words are taken from the following cycle on, and issuing starts the cycle after the last burst word.
- `done_o` follows the final word by exactly one cycle, and idle follows `done_o` by one more.

The bench drives inputs and samples outputs on the falling edge, so each rising-edge transfer shows up at the next sample. It compares the number of words issued, their order and the done timing against a memory model that builds every word from the address and the word index. Hit or miss is judged only from the request pulses seen at the port, so the table's replacement and complete-set invalidation are checked through which later commands reload and which do not.

// File: rtl/ucs_pkg.sv
package ucs_pkg;
  typedef enum logic [1:0] {
    K_EXEC = 2'd0,
    K_PSET = 2'd1,
    K_CSET = 2'd2,
    K_RSVD = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_FILL,
    S_RUN,
    S_DONE
  } state_e;
endpackage

// File: rtl/ucs_rtable.sv
module ucs_rtable #(
  parameter int ADDR_W  = 16,
  parameter int ENTRIES = 4,
  parameter int CNT_W   = 3,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] look_addr_i,
  input  logic              look_cset_i,
  input  logic              look_pset_i,
  input  logic              upd_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  hit_idx_o,
  output logic [IDX_W-1:0]  vic_idx_o
);
  logic [ENTRIES-1:0] valid_q, part_q, live, hit_vec;
  logic [ADDR_W-1:0]  tag_q [ENTRIES];
  logic [CNT_W-1:0]   cnt_q [ENTRIES];

  // a complete set sees partial entries as already gone
  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_ent
      assign live[g]    = valid_q[g] & ~(look_cset_i & part_q[g]);
      assign hit_vec[g] = live[g] && (tag_q[g] == look_addr_i);
    end
  endgenerate

  assign hit_o = |hit_vec;

  always_comb begin
    logic             found_free;
    logic [CNT_W-1:0] min_cnt;
    hit_idx_o  = '0;
    vic_idx_o  = '0;
    found_free = 1'b0;
    min_cnt    = '1;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit_vec[i]) hit_idx_o = IDX_W'(i);
    for (int i = 0; i < ENTRIES; i++)
      if (!live[i] && !found_free) begin
        found_free = 1'b1;
        vic_idx_o  = IDX_W'(i);
      end
    // strict compare keeps the lowest index on ties
    for (int i = 0; i < ENTRIES; i++)
      if (!found_free && cnt_q[i] < min_cnt) begin
        min_cnt   = cnt_q[i];
        vic_idx_o = IDX_W'(i);
      end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      part_q  <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        cnt_q[i] <= '0;
      end
    end else if (upd_i) begin
      if (look_cset_i) valid_q <= valid_q & ~part_q;
      if (hit_o) begin
        if (cnt_q[hit_idx_o] != '1) cnt_q[hit_idx_o] <= cnt_q[hit_idx_o] + CNT_W'(1);
      end else begin
        valid_q[vic_idx_o] <= 1'b1;
        part_q[vic_idx_o]  <= look_pset_i;
        tag_q[vic_idx_o]   <= look_addr_i;
        cnt_q[vic_idx_o]   <= CNT_W'(1);
      end
    end
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec)); // R9
  AST_CSET_PURGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && look_cset_i) |=> $countones(valid_q & part_q) == 0); // R10
endmodule

// File: rtl/ucs_cstore.sv
module ucs_cstore #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ucs_sequencer.sv
module ucs_sequencer #(
  parameter int ADDR_W  = 16,
  parameter int WORD_W  = 16,
  parameter int ENTRIES = 4,
  parameter int BURST   = 4,
  parameter int CNT_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [1:0]        cmd_kind_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              uop_valid_o,
  output logic [WORD_W-1:0] uop_o,
  output logic              busy_o,
  output logic              done_o
);
  import ucs_pkg::*;

  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int OFF_W   = $clog2(BURST);
  localparam int CS_AW   = IDX_W + OFF_W;
  localparam int END_BIT = WORD_W - 1;

  state_e             state_q;
  logic [IDX_W-1:0]   slot_q;
  logic [OFF_W-1:0]   off_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               accept, is_cset, is_pset, hit, last_off;
  logic [IDX_W-1:0]   hit_idx, vic_idx;
  logic [WORD_W-1:0]  rd_word;
  logic [CS_AW-1:0]   cs_addr;

  assign cmd_ready_o = (state_q == S_IDLE);
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign is_cset     = (kind_e'(cmd_kind_i) == K_CSET);
  assign is_pset     = (kind_e'(cmd_kind_i) == K_PSET);
  assign last_off    = (off_q == OFF_W'(BURST - 1));
  assign cs_addr     = {slot_q, off_q};

  ucs_rtable #(
    .ADDR_W (ADDR_W),
    .ENTRIES(ENTRIES),
    .CNT_W  (CNT_W)
  ) u_rtable (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .look_addr_i(cmd_addr_i),
    .look_cset_i(is_cset),
    .look_pset_i(is_pset),
    .upd_i      (accept),
    .hit_o      (hit),
    .hit_idx_o  (hit_idx),
    .vic_idx_o  (vic_idx)
  );

  ucs_cstore #(
    .WORD_W(WORD_W),
    .DEPTH (ENTRIES * BURST)
  ) u_cstore (
    .clk_i  (clk_i),
    .we_i   (state_q == S_FILL && mem_rvalid_i),
    .waddr_i(cs_addr),
    .wdata_i(mem_rdata_i),
    .raddr_i(cs_addr),
    .rdata_o(rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      slot_q  <= '0;
      off_q   <= '0;
      addr_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (accept) begin
          addr_q  <= cmd_addr_i;
          off_q   <= '0;
          slot_q  <= hit ? hit_idx : vic_idx;
          state_q <= hit ? S_RUN : S_REQ;
        end
        S_REQ: state_q <= S_FILL;
        S_FILL: if (mem_rvalid_i) begin
          off_q <= off_q + OFF_W'(1);
          if (last_off) begin
            off_q   <= '0;
            state_q <= S_RUN;
          end
        end
        S_RUN: begin
          off_q <= off_q + OFF_W'(1);
          if (rd_word[END_BIT] || last_off) begin
            off_q   <= '0;
            state_q <= S_DONE;
          end
        end
        S_DONE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (state_q == S_REQ);
  assign mem_addr_o  = addr_q;
  assign uop_valid_o = (state_q == S_RUN);
  assign uop_o       = uop_valid_o ? rd_word : '0;
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_DONE);

  AST_HIT_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && hit) |=> (uop_valid_o && !mem_req_o)); // R2
  AST_MISS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !hit) |=> (mem_req_o && mem_addr_o == $past(cmd_addr_i))); // R3
  AST_REQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> (!mem_req_o && !uop_valid_o)); // R3
  AST_END_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_valid_o && uop_o[END_BIT]) |=> (done_o && !uop_valid_o)); // R5
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o && cmd_ready_o)); // R5
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && busy_o) |=> $stable(addr_q) || !busy_o); // R7
endmodule

// File: tb/ucs_sequencer_tb.sv
`timescale 1ns/1ps
module ucs_sequencer_tb;
  localparam int BURST = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_kind = 2'd0;
  logic [15:0] cmd_addr = '0;
  logic        mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        cmd_ready_o, mem_req_o, uop_valid_o, busy_o, done_o;
  logic [15:0] mem_addr_o, uop_o;

  int checks = 0;
  int errors = 0;
  int nreq   = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  ucs_sequencer u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cmd_valid_i (cmd_valid),
    .cmd_ready_o (cmd_ready_o),
    .cmd_kind_i  (cmd_kind),
    .cmd_addr_i  (cmd_addr),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i (mem_rdata),
    .uop_valid_o (uop_valid_o),
    .uop_o       (uop_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog: act=%0d exp=<50000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // memory model: end bit on word a[1:0], none when a[1:0]==3
  function automatic logic [15:0] mem_word(input logic [15:0] a, input int k);
    logic e;
    e = (k == int'(a[1:0])) && (a[1:0] != 2'd3);
    return {e, a[14:0] ^ 15'(k * 4097)};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    mem_rvalid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_cmd(input logic [1:0] kind, input logic [15:0] addr, input bit exp_miss, input string req);
    int  n0, nw, len;
    bit  words_ok, prev_uop, done_seen, done_ok, first_ok;
    n0 = nreq; nw = 0; words_ok = 1; prev_uop = 0; done_seen = 0; done_ok = 0;
    len = int'(addr[1:0]) + 1;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = kind; cmd_addr = addr;
    while (!cmd_ready_o) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy_o && !cmd_ready_o, "R7", "ready low while busy", cmd_ready_o, 0);
    first_ok = exp_miss ? (mem_req_o && !uop_valid_o) : (uop_valid_o && !mem_req_o);
    chk(first_ok, exp_miss ? "R3" : "R2", "first cycle after accept", {mem_req_o, uop_valid_o}, exp_miss ? 2 : 1);
    for (int g = 0; g < 40 && !done_seen; g++) begin
      if (mem_req_o) begin
        nreq++;
        chk(mem_addr_o == addr, "R3", "burst address", mem_addr_o, addr);
        @(negedge clk);
        for (int k = 0; k < BURST; k++) begin
          mem_rdata = mem_word(addr, k);
          mem_rvalid = 1'b1;
          @(negedge clk);
        end
        mem_rvalid = 1'b0;
        prev_uop = 0;
      end else begin
        if (uop_valid_o) begin
          if (nw >= len || uop_o != mem_word(addr, nw)) words_ok = 0;
          nw++;
          prev_uop = 1;
        end else if (done_o) begin
          done_seen = 1;
          done_ok = prev_uop;
        end else prev_uop = 0;
        if (!done_seen) @(negedge clk);
      end
    end
    chk((nreq - n0) == int'(exp_miss), req, exp_miss ? "expected miss" : "expected hit", nreq - n0, int'(exp_miss));
    chk(words_ok && nw == len, addr[1:0] == 2'd3 ? "R6" : "R4", "issued words", nw, len);
    chk(done_seen && done_ok, "R5", "done one cycle after last word", done_ok, 1);
    @(negedge clk);
    chk(!busy_o && cmd_ready_o && !done_o, "R5", "idle after done", busy_o, 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk(cmd_ready_o && !busy_o && !done_o && !uop_valid_o && !mem_req_o, "R1", "reset outputs",
        {cmd_ready_o, busy_o, done_o, uop_valid_o, mem_req_o}, 5'b10000);
  endtask

  task automatic t_miss_hit();
    do_reset();
    run_cmd(2'd0, 16'h1200, 1, "R3");
    run_cmd(2'd0, 16'h1200, 0, "R2");
    run_cmd(2'd0, 16'h7803, 1, "R6");
    run_cmd(2'd0, 16'h7803, 0, "R6");
    run_cmd(2'd3, 16'h3401, 1, "R8");
    run_cmd(2'd0, 16'h3401, 0, "R8");
    run_cmd(2'd0, 16'h5602, 1, "R4");
  endtask

  task automatic t_replace();
    do_reset();
    run_cmd(2'd0, 16'h1200, 1, "R9");
    run_cmd(2'd0, 16'h3401, 1, "R9");
    run_cmd(2'd0, 16'h5602, 1, "R9");
    run_cmd(2'd0, 16'h7803, 1, "R9");
    for (int i = 0; i < 3; i++) run_cmd(2'd0, 16'h1200, 0, "R9");
    for (int i = 0; i < 2; i++) run_cmd(2'd0, 16'h3401, 0, "R9");
    for (int i = 0; i < 2; i++) run_cmd(2'd0, 16'h5602, 0, "R9");
    run_cmd(2'd0, 16'h9A01, 1, "R9");  // evicts lowest counter (7803)
    run_cmd(2'd0, 16'h1200, 0, "R9");
    run_cmd(2'd0, 16'h3401, 0, "R9");
    run_cmd(2'd0, 16'h5602, 0, "R9");
    run_cmd(2'd0, 16'h7803, 1, "R9");  // evicts 9A01
    run_cmd(2'd0, 16'h9A01, 1, "R9");
  endtask

  task automatic t_cset();
    do_reset();
    run_cmd(2'd1, 16'h2101, 1, "R8");
    run_cmd(2'd0, 16'h2101, 0, "R8");
    run_cmd(2'd0, 16'h1200, 1, "R10");
    run_cmd(2'd2, 16'h4402, 1, "R10");
    run_cmd(2'd0, 16'h2101, 1, "R10"); // partial entry purged
    run_cmd(2'd0, 16'h1200, 0, "R11"); // non-partial entry kept
    run_cmd(2'd2, 16'h4402, 0, "R11"); // loaded by complete set, not partial
    run_cmd(2'd1, 16'h6600, 1, "R8");
    run_cmd(2'd2, 16'h6600, 1, "R10"); // own address was partial
  endtask

  initial begin
    t_reset();
    t_miss_hit();
    t_replace();
    t_cset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule